// File: doc/BRIEF.md
# Instruction Exception Entry Sequencer

This block sits beside the issue stage of a small 32-bit processor core. It takes over when the instruction about to issue must not run. Each cycle it looks at the decoded classification of that instruction, which can flag an illegal encoding, one of two unimplemented-instruction classes, or one of the operations that only supervisor code may run. It also watches a coprocessor's request for a privilege check. The current status register value decides whether the core is at user or supervisor level. When a fault is found, the faulting instruction is never executed, and the block runs a fixed entry sequence.

The sequence latches the original status register and the faulting instruction's own address. It pushes a four-word frame onto the supervisor stack through a 16-bit write port, reads the 32-bit handler address from the vector table at the vector base plus four times the vector number, and then commits three updates in one cycle. These are the redirected program counter, the new status register (supervisor on, tracing off) and the lowered supervisor stack pointer. If the fault came from user level, the user stack pointer is handed out for safekeeping as the sequence starts. A busy output stalls instruction issue for the whole sequence.

Top module: `instr_exc_entry`

## Requirements
- R1: A fault detected in the idle state raises `busy` at the next clock edge. `busy` then stays high for exactly 6 cycles: 4 stack writes, one vector read and one commit cycle. Out of reset `busy`, `mem_we`, `vec_rd` and `pc_we` are low.
- R2: In the commit cycle `sr_we` pulses and `sr_out` equals the latched status register with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared. All other bits are unchanged.
- R3: The vector number is 4 for `cls_illegal`, 10 for `cls_unimpl_a`, 11 for `cls_unimpl_b` and 8 for a privilege violation. The first stacked word is `{4'h0, vector*4}`, with the 12-bit vector offset in bits 11:0.
- R4: The four words are written to consecutive descending addresses: format word at `ssp_in-2`, PC bits 15:0 at `ssp_in-4`, PC bits 31:16 at `ssp_in-6`, and the original status register at `ssp_in-8`. At commit, `ssp_out` is `ssp_in-8`.
- R5: The stacked PC equals `pc_in` as presented with the faulting instruction, not an advanced address.
- R6: With bit 13 of `sr_in` clear, `op_kind` codes 1 through 13 raise a privilege violation. These are the supervisor-only operations: immediate AND/XOR/OR into the status register, status register write, status register read, user stack pointer move, control register move, alternate-space move, coprocessor save, coprocessor restore, external reset, exception return and stop. Codes 0, 14 and 15 never fault, and no code faults with bit 13 set.
- R7: `cp_priv_req` raises a privilege violation (vector 8) when bit 13 of `sr_in` is clear, even without `instr_valid`. It has no effect in supervisor state.
- R8: In the vector-read cycle `vec_rd` is high with `vec_addr = vbr_in + vector*4`. The `vec_rdata` returned one cycle later is driven on `pc_out` with `pc_we` in the commit cycle.
- R9: When several causes are present together, the vector is chosen in the order illegal, then unimplemented class A, then unimplemented class B, then privilege violation.
- R10: When the fault was taken at user level, `usp_we` pulses once in the first cycle of the sequence with `usp_out = usp_in`. At supervisor level it stays low.
- R11: Fault inputs are ignored while `busy` is high. A cause held for the whole sequence starts no second sequence once it is removed before the commit cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A decoded instruction is presented for issue |
| cls_illegal | input | 1 | Instruction is an illegal encoding |
| cls_unimpl_a | input | 1 | Unimplemented instruction, class A |
| cls_unimpl_b | input | 1 | Unimplemented instruction, class B |
| op_kind | input | 4 | Operation kind code; 1..13 are supervisor-only |
| cp_priv_req | input | 1 | Coprocessor asks for a privilege check |
| sr_in | input | 16 | Current status register |
| pc_in | input | ADDR_W | Address of the presented instruction's first word |
| usp_in | input | ADDR_W | Current user stack pointer |
| ssp_in | input | ADDR_W | Current supervisor stack pointer |
| vbr_in | input | ADDR_W | Vector table base |
| busy | output | 1 | Sequence in progress; stalls issue |
| mem_we | output | 1 | Stack word write strobe |
| mem_addr | output | ADDR_W | Stack word write address |
| mem_wdata | output | 16 | Stack word write data |
| vec_rd | output | 1 | Vector table read strobe |
| vec_addr | output | ADDR_W | Vector table read address |
| vec_rdata | input | ADDR_W | Handler address, valid one cycle after `vec_rd` |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | ADDR_W | New program counter |
| sr_we | output | 1 | Status register load strobe |
| sr_out | output | 16 | New status register |
| ssp_we | output | 1 | Supervisor stack pointer load strobe |
| ssp_out | output | ADDR_W | New supervisor stack pointer |
| usp_we | output | 1 | User stack pointer save strobe |
| usp_out | output | ADDR_W | User stack pointer value to save |

## Verification
The bench builds the block with its default `ADDR_W` of 32. At that width the frame holds two PC halves, so program counters with different upper and lower halves show whether the halves are stored in the right order. Stack pointers and vector bases with nonzero low bits show the offset arithmetic for every vector number. Each of the sixteen operation codes is tried at user level, and several at supervisor level, which reaches both the privilege decode and its supervisor bypass.

// File: rtl/xs_pkg.sv
package xs_pkg;

    localparam int SR_W      = 16;
    localparam int WORD_W    = 16;
    localparam int SR_SUPER  = 13;
    localparam int SR_TRACE0 = 14;
    localparam int SR_TRACE1 = 15;

    localparam logic [7:0] VEC_ILLEGAL = 8'd4;
    localparam logic [7:0] VEC_PRIV    = 8'd8;
    localparam logic [7:0] VEC_UNIMP_A = 8'd10;
    localparam logic [7:0] VEC_UNIMP_B = 8'd11;

    // Operation kinds that only supervisor code may run.
    typedef enum logic [3:0] {
        OPK_PLAIN        = 4'd0,
        OPK_AND_IMM_SR   = 4'd1,
        OPK_XOR_IMM_SR   = 4'd2,
        OPK_OR_IMM_SR    = 4'd3,
        OPK_SR_WRITE     = 4'd4,
        OPK_SR_READ      = 4'd5,
        OPK_USP_MOVE     = 4'd6,
        OPK_CTRL_MOVE    = 4'd7,
        OPK_ALT_SPACE    = 4'd8,
        OPK_CP_SAVE      = 4'd9,
        OPK_CP_RESTORE   = 4'd10,
        OPK_EXT_RESET    = 4'd11,
        OPK_EXC_RETURN   = 4'd12,
        OPK_HALT_WAIT    = 4'd13
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [7:0]      vec;
    } fault_ctx_t;

    function automatic logic is_supervisor_only(input logic [3:0] kind);
        return (kind >= OPK_AND_IMM_SR) && (kind <= OPK_HALT_WAIT);
    endfunction

    function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] sr);
        logic [SR_W-1:0] r;
        r            = sr;
        r[SR_SUPER]  = 1'b1;
        r[SR_TRACE1] = 1'b0;
        r[SR_TRACE0] = 1'b0;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] format_word(input logic [7:0] vec);
        return {4'h0, 2'b00, vec, 2'b00};
    endfunction

endpackage

// File: rtl/xs_classify.sv
module xs_classify
    import xs_pkg::*;
(
    input  logic       instr_valid,
    input  logic       cls_illegal,
    input  logic       cls_unimpl_a,
    input  logic       cls_unimpl_b,
    input  logic [3:0] op_kind,
    input  logic       cp_priv_req,
    input  logic       supervisor,
    output logic       fault,
    output logic [7:0] vec
);
    logic priv_hit;

    always_comb begin
        priv_hit = !supervisor &&
                   ((instr_valid && is_supervisor_only(op_kind)) || cp_priv_req);
        fault = 1'b1;
        vec   = VEC_PRIV;
        if (instr_valid && cls_illegal)       vec = VEC_ILLEGAL;
        else if (instr_valid && cls_unimpl_a) vec = VEC_UNIMP_A;
        else if (instr_valid && cls_unimpl_b) vec = VEC_UNIMP_B;
        else if (priv_hit)                    vec = VEC_PRIV;
        else                                  fault = 1'b0;
    end
endmodule

// File: rtl/xs_frame.sv
module xs_frame
    import xs_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int PC_WORDS    = ADDR_W / WORD_W,
    localparam int FRAME_WORDS = PC_WORDS + 2,
    localparam int IDX_W       = $clog2(FRAME_WORDS)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] ssp,
    input  logic [ADDR_W-1:0] pc,
    input  fault_ctx_t        ctx,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);
    localparam int WORD_BYTES = WORD_W / 8;

    logic [WORD_W-1:0] words [FRAME_WORDS];

    // Highest address first: format word, PC low to high, status last.
    assign words[0]             = format_word(ctx.vec);
    assign words[FRAME_WORDS-1] = ctx.sr;

    for (genvar g = 0; g < PC_WORDS; g++) begin : g_pc_word
        assign words[1+g] = pc[WORD_W*g +: WORD_W];
    end

    assign data = words[idx];
    assign addr = ssp - ((ADDR_W'(idx) + ADDR_W'(1)) * ADDR_W'(WORD_BYTES));
endmodule

// File: rtl/instr_exc_entry.sv
module instr_exc_entry
    import xs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic              cls_illegal,
    input  logic              cls_unimpl_a,
    input  logic              cls_unimpl_b,
    input  logic [3:0]        op_kind,
    input  logic              cp_priv_req,
    input  logic [15:0]       sr_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] usp_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic [ADDR_W-1:0] vec_rdata,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_out,
    output logic              sr_we,
    output logic [15:0]       sr_out,
    output logic              ssp_we,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              usp_we,
    output logic [ADDR_W-1:0] usp_out
);
    localparam int PC_WORDS    = ADDR_W / WORD_W;
    localparam int FRAME_WORDS = PC_WORDS + 2;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int FRAME_BYTES = FRAME_WORDS * (WORD_W / 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    fault_ctx_t        ctx;
    logic [ADDR_W-1:0] ctx_pc, ctx_ssp, ctx_usp, ctx_vbr;

    logic       fault;
    logic [7:0] fault_vec;

    xs_classify u_classify (
        .instr_valid (instr_valid),
        .cls_illegal (cls_illegal),
        .cls_unimpl_a(cls_unimpl_a),
        .cls_unimpl_b(cls_unimpl_b),
        .op_kind     (op_kind),
        .cp_priv_req (cp_priv_req),
        .supervisor  (sr_in[SR_SUPER]),
        .fault       (fault),
        .vec         (fault_vec)
    );

    xs_frame #(.ADDR_W(ADDR_W)) u_frame (
        .idx (idx),
        .ssp (ctx_ssp),
        .pc  (ctx_pc),
        .ctx (ctx),
        .addr(mem_addr),
        .data(mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            ctx     <= '0;
            ctx_pc  <= '0;
            ctx_ssp <= '0;
            ctx_usp <= '0;
            ctx_vbr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (fault) begin
                    state   <= ST_PUSH;
                    idx     <= '0;
                    ctx.sr  <= sr_in;
                    ctx.vec <= fault_vec;
                    ctx_pc  <= pc_in;
                    ctx_ssp <= ssp_in;
                    ctx_usp <= usp_in;
                    ctx_vbr <= vbr_in;
                end
                ST_PUSH: begin
                    if (idx == LAST_IDX) state <= ST_VEC;
                    else                 idx   <= idx + 1'b1;
                end
                ST_VEC:  state <= ST_LOAD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        mem_we   = (state == ST_PUSH);
        usp_we   = (state == ST_PUSH) && (idx == '0) && !ctx.sr[SR_SUPER];
        usp_out  = ctx_usp;
        vec_rd   = (state == ST_VEC);
        vec_addr = ctx_vbr + (ADDR_W'(ctx.vec) << 2);
        pc_we    = (state == ST_LOAD);
        pc_out   = vec_rdata;
        sr_we    = (state == ST_LOAD);
        sr_out   = entry_sr(ctx.sr);
        ssp_we   = (state == ST_LOAD);
        ssp_out  = ctx_ssp - ADDR_W'(FRAME_BYTES);
    end

    AST_ENTRY_PUSHES: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_we);                                          // R1
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, vec_rd, pc_we}));                               // R1
    AST_SR_ENTRY_BITS: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> (sr_out[SR_SUPER] && !sr_out[SR_TRACE1] && !sr_out[SR_TRACE0])); // R2
    AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(2))); // R4
    AST_FETCH_BEFORE_JUMP: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> $past(vec_rd));                                         // R8
    AST_ILLEGAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!busy && instr_valid && cls_illegal) |=>
            (mem_we && mem_wdata == format_word(VEC_ILLEGAL)));           // R9
    AST_SUPER_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!busy && sr_in[SR_SUPER] && !cls_illegal && !cls_unimpl_a && !cls_unimpl_b)
            |=> !busy);                                                   // R6
    AST_USP_AT_START: assert property (@(posedge clk) disable iff (rst)
        usp_we |-> $rose(busy));                                          // R10
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && !pc_we) |=> busy);                                       // R11
endmodule

// File: tb/test_instr_exc_entry.sv
module test_instr_exc_entry;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 0, cls_illegal = 0, cls_unimpl_a = 0, cls_unimpl_b = 0;
    logic [3:0]  op_kind = 0;
    logic        cp_priv_req = 0;
    logic [15:0] sr_in = 0;
    logic [31:0] pc_in = 0, usp_in = 0, ssp_in = 0, vbr_in = 0;
    logic        busy, mem_we, vec_rd, pc_we, sr_we, ssp_we, usp_we;
    logic [31:0] mem_addr, vec_addr, pc_out, ssp_out, usp_out;
    logic [31:0] vec_rdata = 0;
    logic [15:0] mem_wdata, sr_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Vector table model: one-cycle read latency.
    always @(posedge clk) if (vec_rd) vec_rdata <= 32'hA000_0000 ^ vec_addr;

    instr_exc_entry i_instr_exc_entry (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .cls_illegal(cls_illegal),
        .cls_unimpl_a(cls_unimpl_a), .cls_unimpl_b(cls_unimpl_b), .op_kind(op_kind),
        .cp_priv_req(cp_priv_req), .sr_in(sr_in), .pc_in(pc_in), .usp_in(usp_in),
        .ssp_in(ssp_in), .vbr_in(vbr_in), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .vec_rd(vec_rd), .vec_addr(vec_addr),
        .vec_rdata(vec_rdata), .pc_we(pc_we), .pc_out(pc_out), .sr_we(sr_we),
        .sr_out(sr_out), .ssp_we(ssp_we), .ssp_out(ssp_out), .usp_we(usp_we),
        .usp_out(usp_out)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        instr_valid = 0; cls_illegal = 0; cls_unimpl_a = 0; cls_unimpl_b = 0;
        op_kind = 0; cp_priv_req = 0;
    endtask

    // Inputs are set by the caller at a negedge; runs one sequence and checks it.
    task automatic run_case(input string tag, input bit exp_fault,
                            input logic [7:0] exp_vec, input bit hold);
        int nb = 0, nw = 0, nu = 0, nc = 0;
        logic [31:0] wa [4];
        logic [15:0] wd [4];
        logic [31:0] va = 0, pcv = 0, ssv = 0, uv = 0;
        logic [15:0] srv = 0;
        logic [31:0] ssp0 = ssp_in, pc0 = pc_in, vbr0 = vbr_in, usp0 = usp_in;
        logic [15:0] sr0 = sr_in;
        bit user = !sr_in[13];
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (busy) nb++;
            if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
            if (usp_we) begin nu++; uv = usp_out; end
            if (vec_rd) va = vec_addr;
            if (pc_we) begin nc++; pcv = pc_out; srv = sr_out; ssv = ssp_out; end
            if ((k == 1 && !hold) || (k == 6 && hold)) clear_inputs();
        end
        if (!exp_fault) begin
            chk({tag, " busy cycles"}, nb, 0);
            chk({tag, " stack writes"}, nw, 0);
            return;
        end
        chk({tag, " R1 busy cycles"}, nb, 6);
        chk({tag, " R4/R11 stack writes"}, nw, 4);
        chk({tag, " R2 commit count"}, nc, 1);
        if (nw == 4) begin
            chk({tag, " R3 format word"}, {16'h0, wd[0]}, {20'h0, 2'b00, exp_vec, 2'b00});
            chk({tag, " R4 top address"}, wa[0], ssp0 - 2);
            chk({tag, " R4 pc-low address"}, wa[1], ssp0 - 4);
            chk({tag, " R4 pc-high address"}, wa[2], ssp0 - 6);
            chk({tag, " R4 sr address"}, wa[3], ssp0 - 8);
            chk({tag, " R5 stacked pc low"}, {16'h0, wd[1]}, {16'h0, pc0[15:0]});
            chk({tag, " R5 stacked pc high"}, {16'h0, wd[2]}, {16'h0, pc0[31:16]});
            chk({tag, " R4 stacked sr"}, {16'h0, wd[3]}, {16'h0, sr0});
        end
        chk({tag, " R8 vector address"}, va, vbr0 + {22'h0, exp_vec, 2'b00});
        chk({tag, " R8 handler pc"}, pcv, 32'hA000_0000 ^ (vbr0 + {22'h0, exp_vec, 2'b00}));
        chk({tag, " R2 new sr"}, {16'h0, srv}, {16'h0, (sr0 | 16'h2000) & 16'h3FFF});
        chk({tag, " R4 new ssp"}, ssv, ssp0 - 8);
        chk({tag, " R10 usp save count"}, nu, user ? 1 : 0);
        if (user) chk({tag, " R10 usp value"}, uv, usp0);
    endtask

    task automatic setup(input logic [15:0] sr, input logic [31:0] pc);
        @(negedge clk);
        clear_inputs();
        sr_in = sr; pc_in = pc; usp_in = 32'h0000_7F3C;
        ssp_in = 32'h0001_0F06; vbr_in = 32'h0000_0404;
        instr_valid = 1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset mem_we", mem_we, 0);
        chk("R1 reset vec_rd", vec_rd, 0);
        chk("R1 reset pc_we", pc_we, 0);
    endtask

    task automatic t_illegal_user();
        setup(16'hC01F, 32'h1234_5678); cls_illegal = 1;
        run_case("R3 illegal user", 1, 8'd4, 0);
    endtask

    task automatic t_unimpl_super();
        setup(16'h2704, 32'hCAFE_0102); cls_unimpl_a = 1;
        run_case("R3 unimpl A super", 1, 8'd10, 0);
        setup(16'h8000, 32'h0000_FFFE); cls_unimpl_b = 1;
        run_case("R3 unimpl B user", 1, 8'd11, 0);
    endtask

    task automatic t_priv_codes();
        for (int c = 0; c < 16; c++) begin
            setup(16'h4010, 32'h0040_0000 + c * 2); op_kind = 4'(c);
            run_case("R6 user op code", (c >= 1 && c <= 13), 8'd8, 0);
        end
        setup(16'h2000, 32'h0000_1000); op_kind = 4'd5;
        run_case("R6 supervisor op code 5", 0, 8'd8, 0);
        setup(16'hE000, 32'h0000_1002); op_kind = 4'd13;
        run_case("R6 supervisor op code 13", 0, 8'd8, 0);
    endtask

    task automatic t_cp_req();
        setup(16'h0000, 32'h0000_2000); instr_valid = 0; cp_priv_req = 1;
        run_case("R7 coprocessor user", 1, 8'd8, 0);
        setup(16'h2000, 32'h0000_2004); instr_valid = 0; cp_priv_req = 1;
        run_case("R7 coprocessor supervisor", 0, 8'd8, 0);
    endtask

    task automatic t_priority();
        setup(16'h0000, 32'h0000_3000);
        cls_illegal = 1; cls_unimpl_a = 1; cls_unimpl_b = 1; op_kind = 4'd1;
        run_case("R9 illegal wins", 1, 8'd4, 0);
        setup(16'h0000, 32'h0000_3002);
        cls_unimpl_a = 1; cls_unimpl_b = 1; cp_priv_req = 1;
        run_case("R9 class A wins", 1, 8'd10, 0);
        setup(16'h0000, 32'h0000_3004);
        cls_unimpl_b = 1; op_kind = 4'd12;
        run_case("R9 class B wins", 1, 8'd11, 0);
    endtask

    task automatic t_busy_ignore();
        setup(16'h0700, 32'h8765_4320); cls_illegal = 1;
        run_case("R11 held cause", 1, 8'd4, 1);
        @(negedge clk);
        chk("R11 no restart", busy, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset();
        t_illegal_user();
        t_unimpl_super();
        t_priv_codes();
        t_cp_req();
        t_priority();
        t_busy_ignore();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule